// File: doc/BRIEF.md
# Recursive-FIR Sample Filter

This block filters a single stream of signed ADC samples. Every accepted sample passes through a five-tap FIR section. A first-order feedback term is added to the result, and the sum is divided by a programmable power of two. The output is saturated to the output width and presented with a one-cycle valid pulse. The filtered value is registered, and that register also supplies the feedback term.

Software loads the coefficients one byte at a time into a 16-byte staging area. Writing the last byte moves the whole staged set into the working set on that clock edge. A half-written set therefore never reaches the datapath, and the datapath keeps running across the update.

Top module: `sample_filter`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` is 0, the sample history and feedback value are 0, and all working and staged coefficients are 0, so a sample taken before any commit produces 0.
- R2: Coefficient k (k = 1..8) is a 16-bit two's-complement value held little-endian: its low byte is at byte address 2k-2 and its high byte at 2k-1. Coefficients 1..5 weight x[n], x[n-1], x[n-2], x[n-3] and x[n-4] in that order.
- R3: A write to byte addresses 0..14 only stages the byte; it leaves the working coefficients, and hence the filtered output, unchanged.
- R4: A write to byte address 15 moves all 16 staged bytes (with the new byte 15) into the working set at that edge. A sample accepted in the same cycle still uses the old set; the next sample uses the new set.
- R5: When `in_valid` is 1 at a rising edge, `out_data` after that edge equals sat((c1·x[n] + c2·x[n-1] + c3·x[n-2] + c4·x[n-3] + c5·x[n-4] + c6·y[n-1]) >>> s), and `out_valid` is 1 for that one cycle.
- R6: y[n-1] in the feedback term is the previous saturated value of `out_data`.
- R7: The divide is an arithmetic right shift by s, which rounds toward minus infinity (for example, -3 shifted by 1 gives -2).
- R8: s is coefficient 8 read as an unsigned 16-bit number, clamped to 11 when it exceeds 11.
- R9: The sum is computed with no intermediate overflow. The shifted result saturates to the signed range of `out_data`: 32767 at the top and -32768 at the bottom for the default width.
- R10: Coefficient 7 has no effect on the output.
- R11: Without `in_valid`, the sample history does not advance, `out_valid` is 0 and `out_data` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DW (16) | Signed input sample |
| cfg_we | input | 1 | Coefficient byte write strobe |
| cfg_addr | input | 4 | Byte address in the staging area |
| cfg_wdata | input | 8 | Byte to write |
| out_valid | output | 1 | Filtered sample strobe |
| out_data | output | OW (16) | Signed saturated filtered sample |

## Verification
The filtered value for a sample strobed at a rising edge is due right after that edge, with no further latency. The bench drives stimulus on the falling edge and reads `out_valid` and `out_data` 1 ns after the next rising edge.

A coefficient commit is due at the same edge as the write of byte 15. The bench checks it by strobing a sample in that very cycle and expecting the old set, then strobing the next sample and expecting the new set. Partial writes and idle cycles are checked at the next rising edge by comparing the output with the model's value from before the stimulus.

// File: rtl/sample_filter.sv
`timescale 1ns/1ps
module sample_filter #(
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int OW     = 16,
  parameter int NTAP   = 5,
  parameter int MAXDIV = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic                 cfg_we,
  input  logic [3:0]           cfg_addr,
  input  logic [7:0]           cfg_wdata,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  localparam int NCOEF = 8;
  localparam int NBYTE = 2 * NCOEF;
  localparam int FBI   = NTAP;
  localparam int DIVI  = NCOEF - 1;
  localparam int SW    = $clog2(MAXDIV + 1);
  localparam int XW    = (DW > OW) ? DW : OW;
  localparam int AW    = XW + CW + $clog2(NTAP + 1) + 1;
  localparam logic signed [AW-1:0] OMAX = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [AW-1:0] OMIN = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  logic [7:0]            stage [NBYTE];
  logic [NBYTE*8-1:0]    staged;
  logic [NBYTE*8-1:0]    act;
  logic                  commit;
  logic signed [DW-1:0]  hist [NTAP-1];
  logic signed [DW-1:0]  xs   [NTAP];
  logic signed [AW-1:0]  term [NTAP+1];
  logic signed [AW-1:0]  acc, shifted;
  logic [CW-1:0]         div_raw;
  logic [SW-1:0]         sh;
  logic signed [OW-1:0]  ysat;

  assign commit = cfg_we && (cfg_addr == 4'(NBYTE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBYTE; b++) stage[b] <= '0;
    end else if (cfg_we) begin
      stage[cfg_addr] <= cfg_wdata;
    end
  end

  always_comb begin
    for (int b = 0; b < NBYTE - 1; b++) staged[b*8 +: 8] = stage[b];
    staged[(NBYTE-1)*8 +: 8] = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act <= '0;
    else if (commit) act <= staged;
  end

  genvar i;
  generate
    for (i = 0; i < NTAP; i++) begin : g_tap
      if (i == 0) begin : g_head
        assign xs[i] = in_data;
      end else begin : g_body
        assign xs[i] = hist[i-1];
      end
      assign term[i] = AW'($signed(act[i*CW +: CW])) * AW'(xs[i]);
    end
  endgenerate

  assign term[NTAP] = AW'($signed(act[FBI*CW +: CW])) * AW'(out_data);

  always_comb begin
    acc = '0;
    for (int k = 0; k <= NTAP; k++) acc = acc + term[k];
  end

  assign div_raw = act[DIVI*CW +: CW];
  assign sh      = (div_raw > CW'(MAXDIV)) ? SW'(MAXDIV) : SW'(div_raw);
  assign shifted = acc >>> sh;
  assign ysat    = (shifted > OMAX) ? OMAX[OW-1:0] :
                   (shifted < OMIN) ? OMIN[OW-1:0] : shifted[OW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAP - 1; k++) hist[k] <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        hist[0] <= in_data;
        for (int k = 1; k < NTAP - 1; k++) hist[k] <= hist[k-1];
        out_data <= ysat;
      end
    end
  end

  assert_coef_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act));

  assert_valid_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data)));

  assert_hist_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(hist[NTAP-2]) && $stable(hist[0]));

  assert_commit_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> act[NBYTE*8-1 -: 8] == $past(cfg_wdata));
endmodule

// File: tb/sample_filter_tb.sv
`timescale 1ns/1ps
module sample_filter_tb_top;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, cfg_we = 0;
  logic signed [15:0] in_data = 0;
  logic [3:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0;
  logic out_valid;
  logic signed [15:0] out_data;

  int nchk = 0, nerr = 0;
  bit done = 0;

  logic [7:0]  msh [16];
  logic [15:0] mc  [8];
  longint mx [4];
  longint my;

  sample_filter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_data(out_data));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model_out(input longint x);
    longint acc, v;
    int sh;
    acc = longint'($signed(mc[0])) * x;
    for (int k = 1; k < 5; k++) acc += longint'($signed(mc[k])) * mx[k-1];
    acc += longint'($signed(mc[5])) * my;
    sh = (mc[7] > 11) ? 11 : int'(mc[7]);
    v = acc >>> sh;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  task automatic model_write(input int a, input logic [7:0] d);
    msh[a] = d;
    if (a == 15)
      for (int k = 0; k < 8; k++) mc[k] = {msh[2*k+1], msh[2*k]};
  endtask

  task automatic wbyte(input int a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
    @(posedge clk); #1;
    model_write(a, d);
    cfg_we = 0;
  endtask

  task automatic set_coefs(input logic [15:0] c [8]);
    for (int k = 0; k < 8; k++) begin
      wbyte(2*k, c[k][7:0]);
      wbyte(2*k+1, c[k][15:8]);
    end
  endtask

  task automatic feed(input logic signed [15:0] x, input bit we, input int a,
                      input logic [7:0] d, input string req);
    longint e;
    @(negedge clk);
    in_valid = 1; in_data = x;
    cfg_we = we; cfg_addr = 4'(a); cfg_wdata = d;
    @(posedge clk); #1;
    e = model_out(longint'(x));
    for (int k = 3; k > 0; k--) mx[k] = mx[k-1];
    mx[0] = longint'(x);
    my = e;
    if (we) model_write(a, d);
    chk(out_valid == 1'b1, req, longint'(out_valid), 1);
    chk(longint'(out_data) == e, req, longint'(out_data), e);
    in_valid = 0; cfg_we = 0;
  endtask

  task automatic samp(input logic signed [15:0] x, input string req);
    feed(x, 0, 0, 8'h00, req);
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    in_valid = 0; in_data = 16'sh1234;
    @(posedge clk); #1;
    chk(out_valid == 1'b0, req, longint'(out_valid), 0);
    chk(longint'(out_data) == my, req, longint'(out_data), my);
  endtask

  function automatic void mk(output logic [15:0] c [8], input logic [15:0] c1,
      input logic [15:0] c2, input logic [15:0] c3, input logic [15:0] c6,
      input logic [15:0] c7, input logic [15:0] c8);
    c[0] = c1; c[1] = c2; c[2] = c3; c[3] = 0; c[4] = 0;
    c[5] = c6; c[6] = c7; c[7] = c8;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [15:0] c [8];
    void'($urandom(32'd20240611));
    for (int k = 0; k < 16; k++) msh[k] = 0;
    for (int k = 0; k < 8; k++) mc[k] = 0;
    for (int k = 0; k < 4; k++) mx[k] = 0;
    my = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 reset valid", longint'(out_valid), 0);
    chk(out_data == 16'sd0, "R1 reset data", longint'(out_data), 0);
    @(negedge clk); rst_n = 1;
    samp(16'sd1234, "R1 zero coefficients");

    mk(c, 16'd1, 0, 0, 0, 0, 0);
    for (int b = 0; b < 15; b++) wbyte(b, (b == 0) ? 8'd1 : 8'd0);
    samp(16'sd500, "R3 staged bytes inactive");
    idle("R11 idle after partial write");
    wbyte(15, 8'd0);
    samp(16'sd100, "R5 impulse tap1");
    samp(16'sd0, "R5 impulse tail");

    mk(c, 0, 0, 16'd2, 0, 0, 0);
    set_coefs(c);
    samp(16'sd7, "R2 tap3 lead");
    samp(16'sd0, "R2 tap3 wait");
    samp(16'sd0, "R2 tap3 hit");
    samp(16'sd0, "R2 tap3 tail");

    mk(c, 16'd1, 0, 0, 16'd1, 0, 16'd1);
    set_coefs(c);
    samp(16'sd100, "R6 feedback first");
    samp(16'sd0, "R6 feedback decay");
    samp(16'sd0, "R6 feedback decay 2");

    mk(c, 16'd1, 0, 0, 0, 0, 16'd1);
    set_coefs(c);
    samp(-16'sd3, "R7 arithmetic shift");
    chk(out_data == -16'sd2, "R7 direct -3>>>1", longint'(out_data), -2);

    mk(c, 16'd1000, 0, 0, 0, 0, 16'd200);
    set_coefs(c);
    samp(16'sd4096, "R8 clamp to 11");
    chk(out_data == 16'sd2000, "R8 direct", longint'(out_data), 2000);

    mk(c, 16'd32767, 0, 0, 0, 0, 0);
    set_coefs(c);
    samp(16'sd32767, "R9 saturate high");
    chk(out_data == 16'sd32767, "R9 direct high", longint'(out_data), 32767);
    samp(-16'sd32768, "R9 saturate low");
    chk(out_data == -16'sd32768, "R9 direct low", longint'(out_data), -32768);

    mk(c, 16'd3, 16'hFFFF, 0, 0, 16'h7ABC, 16'd1);
    set_coefs(c);
    samp(16'sd40, "R10 reserved ignored");
    samp(-16'sd20, "R10 reserved ignored 2");
    chk(out_data == -16'sd50, "R10 direct", longint'(out_data), -50);

    mk(c, 16'd5, 0, 0, 0, 0, 0);
    for (int b = 0; b < 15; b++) wbyte(b, (b == 0) ? 8'd5 : 8'd0);
    feed(16'sd10, 1, 15, 8'd0, "R4 same-cycle uses old set");
    samp(16'sd10, "R4 next sample uses new set");
    chk(out_data == 16'sd50, "R4 direct", longint'(out_data), 50);
    idle("R11 idle hold");
    samp(16'sd1, "R11 history not advanced");

    for (int it = 0; it < 1500; it++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 5) samp(16'($urandom), "R5 random sample");
      else if (r < 7) begin
        int a;
        logic [7:0] d;
        a = int'($urandom_range(0, 15));
        d = 8'($urandom);
        if (a == 15 || a == 14) d = 8'($urandom_range(0, 1));
        if (a == 11 || a == 10) d = 8'($urandom_range(0, 255)) >> 4;
        if (a == 15) feed(16'($urandom), 1, 15, 8'($urandom_range(0, 1)), "R4 random commit");
        else wbyte(a, d);
      end else if (r < 8) idle("R11 random idle");
      else begin
        mk(c, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom_range(0, 3)),
           16'($urandom), 16'($urandom_range(0, 14)));
        c[3] = 16'($urandom); c[4] = 16'($urandom);
        set_coefs(c);
        samp(16'($urandom), "R2 random set");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule